// File: doc/BRIEF.md
# Divided Clock Tree for Pixel and Byte Clocks

This block turns one fast oscillator into two derived clocks for a serial display link: a pixel clock and a byte clock. The pixel clock comes from a single programmable divider fed directly by the oscillator phase. The byte clock passes through a two-way selector and then a fixed divide-by-four stage. The selector picks either the oscillator phase itself or an indirect route, which is a programmable post-divider followed by a fixed halving stage.

All logic runs on one input clock `clk`, which runs at twice the oscillator rate. A toggle flop inside the block recreates the oscillator phase, so one oscillator period lasts two `clk` cycles. Every derived clock is a registered level in the `clk` domain, and every stage updates on the same edge. Divide ratios are taken only at the start of an output period. The selector changes only while both of its inputs are low. Together these rules keep reprogramming free of runt pulses. A global disable holds both outputs low and clears every stage.

Top module: `clk_div_tree`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, both outputs are low after that edge and every stage counter is cleared.
- R2: The pixel clock is the oscillator divided by N+1, where N = `pix_cfg_i[7:0]`. One oscillator period is 2 `clk` cycles. For an even ratio M the high and low phases are each M `clk` cycles. For an odd ratio M > 1 the high phase is M+1 `clk` cycles and the low phase is M-1 `clk` cycles.
- R3: When N = 0 the pixel clock equals the oscillator phase: high for 1 `clk` cycle and low for 1 `clk` cycle.
- R4: When `mux_cfg_i` bit 1 is 0, the byte clock is the oscillator divided by 4: high for 4 cycles and low for 4 cycles.
- R5: When `mux_cfg_i` bit 1 is 1, the byte clock is the oscillator divided by (P+1), then by 2, then by 4, where P = `post_cfg_i[3:0]`. The result is high for 8(P+1) cycles and low for 8(P+1) cycles.
- R6: Bits 7..4 of `post_cfg_i` and every bit of `mux_cfg_i` except bit 1 have no effect on the outputs.
- R7: A new divide value written during an output period takes effect at the next rising edge of that output. The period already in progress completes with the old high and low lengths.
- R8: While `disable_i` is high, both outputs are low from the next edge on. After `disable_i` is released, both outputs rise at the first edge, because all counters restart from zero.
- R9: The selector switches only when both of its inputs are low. Every rise of an output coincides with a rise of the oscillator phase. No byte clock phase shorter than 4 cycles ever appears, even while the select bit toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the oscillator rate |
| rst_n | input | 1 | Synchronous active-low reset |
| disable_i | input | 1 | Global disable: holds outputs low and clears counters |
| post_cfg_i | input | 8 | Post-divider register; bits 3..0 hold the divide value P |
| mux_cfg_i | input | 8 | Selector register; bit 1 picks the indirect route |
| pix_cfg_i | input | 8 | Pixel divider register; bits 7..0 hold the divide value N |
| pix_clk_o | output | 1 | Pixel clock |
| byte_clk_o | output | 1 | Byte clock |

## Verification
A wrong counter, or a divide value latched mid-period, shows up at the ports as a wrong high or low run length. The error appears within one output period, which is at most 512 cycles for the pixel clock and 256 cycles for the byte clock. A selector switched at the wrong moment shows up as a byte clock phase shorter than four cycles, on the first byte period after the toggle. A counter that a disable fails to clear shows up on the very first sample after release: one of the outputs is not high, or the first pixel high phase has the wrong length.

// File: rtl/clk_tree_pkg.sv
// Package: shared constants for the divided clock tree.
// Assumes every programmable divider encodes a ratio as value+1.
package clk_tree_pkg;
    localparam int          FIXED_W      = 2;     // width of fixed-stage codes
    localparam logic [1:0]  HALF_CODE    = 2'd1;  // divide-by-2 stage
    localparam logic [1:0]  QUARTER_CODE = 2'd3;  // divide-by-4 stage, forced
    localparam int          MUX_SEL_BIT  = 1;     // byte selector bit position
endpackage

// File: rtl/ctree_osc_phase.sv
// Module: recreates the oscillator phase from a clock at twice its rate.
// Assumes clr_i returns the phase to low so that restarts are deterministic.
module ctree_osc_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic ph_nxt_o,
    output logic ph_q_o
);
    logic ph_q;

    assign ph_nxt_o = clr_i ? 1'b0 : ~ph_q;
    assign ph_q_o   = ph_q;

    // Toggle the phase each cycle unless cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_nxt_o;
    end
endmodule

// File: rtl/ctree_div_stage.sv
// Module: divides an input level by ratio_i+1, counting input rising edges.
// The input is given as a next/current pair, so this stage updates on the
// same edge as its source. A value of 0 passes the input through. The ratio
// is sampled only at an output period start. For odd ratios the high phase
// is one input period longer than the low phase.
module ctree_div_stage #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               in_nxt_i,
    input  logic               in_cur_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               out_nxt_o,
    output logic               out_q_o
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] cnt_q, cnt_d, n_q, n_d, n_use;
    logic               out_q, out_d, rise;

    assign rise      = in_nxt_i & ~in_cur_i;
    assign n_use     = (cnt_q == '0) ? ratio_i : n_q;
    assign out_nxt_o = out_d;
    assign out_q_o   = out_q;

    // Next-state: count input rises, set the duty phase, follow input at ratio 1.
    always_comb begin
        cnt_d = cnt_q;
        n_d   = n_q;
        out_d = out_q;
        if (clr_i) begin
            cnt_d = '0;
            n_d   = '0;
            out_d = 1'b0;
        end else if (rise) begin
            n_d   = n_use;
            out_d = (cnt_q <= (n_use >> 1));
            cnt_d = (cnt_q == n_use) ? '0 : cnt_q + ONE;
        end else if (n_q == '0) begin
            out_d = in_nxt_i;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            n_q   <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            n_q   <= n_d;
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/ctree_safe_mux.sv
// Module: two-way level selector that adopts a new select only when both
// inputs are low in the next cycle, so no partial pulse reaches its output.
// Assumes both inputs are next/current level pairs from the same domain.
module ctree_safe_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sel_req_i,
    input  logic a_nxt_i,
    input  logic a_cur_i,
    input  logic b_nxt_i,
    input  logic b_cur_i,
    output logic sel_q_o,
    output logic out_nxt_o,
    output logic out_cur_o
);
    logic sel_q, sel_d;

    assign sel_d     = (clr_i || (!a_nxt_i && !b_nxt_i)) ? sel_req_i : sel_q;
    assign out_nxt_o = sel_d ? b_nxt_i : a_nxt_i;
    assign out_cur_o = sel_q ? b_cur_i : a_cur_i;
    assign sel_q_o   = sel_q;

    // Hold the active select; update it only in a quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end
endmodule

// File: rtl/clk_div_tree.sv
// Module: pixel and byte clock divider tree.
// Pixel clock: oscillator / (pix value + 1).
// Byte clock: selector (oscillator, or oscillator / (post value + 1) / 2), then / 4.
// Assumes clk runs at twice the oscillator rate; all outputs are registered levels.
module clk_div_tree
    import clk_tree_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int POST_W = 4,
    parameter int PIX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disable_i,
    input  logic [CFG_W-1:0] post_cfg_i,
    input  logic [CFG_W-1:0] mux_cfg_i,
    input  logic [PIX_W-1:0] pix_cfg_i,
    output logic             pix_clk_o,
    output logic             byte_clk_o
);
    logic vco_nxt, vco_q;
    logic post_nxt, post_q;
    logic half_nxt, half_q;
    logic mux_nxt, mux_cur, mux_sel_q;
    logic pix_nxt, byte_nxt;
    logic unused_cfg_bits;

    // Only the post field and the select bit are decoded.
    assign unused_cfg_bits = ^{post_cfg_i, mux_cfg_i, pix_nxt, byte_nxt};

    ctree_osc_phase u_osc (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .ph_nxt_o(vco_nxt), .ph_q_o(vco_q)
    );

    ctree_div_stage #(.RATIO_W(PIX_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .in_nxt_i(vco_nxt), .in_cur_i(vco_q), .ratio_i(pix_cfg_i),
        .out_nxt_o(pix_nxt), .out_q_o(pix_clk_o)
    );

    ctree_div_stage #(.RATIO_W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .in_nxt_i(vco_nxt), .in_cur_i(vco_q), .ratio_i(post_cfg_i[POST_W-1:0]),
        .out_nxt_o(post_nxt), .out_q_o(post_q)
    );

    ctree_div_stage #(.RATIO_W(FIXED_W)) u_half (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .in_nxt_i(post_nxt), .in_cur_i(post_q), .ratio_i(HALF_CODE),
        .out_nxt_o(half_nxt), .out_q_o(half_q)
    );

    ctree_safe_mux u_mux (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .sel_req_i(mux_cfg_i[MUX_SEL_BIT]),
        .a_nxt_i(vco_nxt), .a_cur_i(vco_q),
        .b_nxt_i(half_nxt), .b_cur_i(half_q),
        .sel_q_o(mux_sel_q), .out_nxt_o(mux_nxt), .out_cur_o(mux_cur)
    );

    ctree_div_stage #(.RATIO_W(FIXED_W)) u_quarter (
        .clk(clk), .rst_n(rst_n), .clr_i(disable_i),
        .in_nxt_i(mux_nxt), .in_cur_i(mux_cur), .ratio_i(QUARTER_CODE),
        .out_nxt_o(byte_nxt), .out_q_o(byte_clk_o)
    );
endmodule

// File: rtl/clk_div_tree_chk.sv
// Module: assertion checker for clk_div_tree, attached by bind.
// Assumes access to the oscillator phase and the selector state.
module clk_div_tree_chk (
    input logic clk,
    input logic rst_n,
    input logic disable_i,
    input logic pix_clk_o,
    input logic byte_clk_o,
    input logic vco_q,
    input logic mux_sel_q,
    input logic mux_cur
);
    logic [7:0] hi_run_q, lo_run_q;

    // Track the current byte high and low run lengths, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= byte_clk_o ? ((hi_run_q == 8'hFF) ? hi_run_q : hi_run_q + 8'd1) : 8'd0;
            lo_run_q <= byte_clk_o ? 8'd0 : ((lo_run_q == 8'hFF) ? lo_run_q : lo_run_q + 8'd1);
        end
    end

    assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (!pix_clk_o && !byte_clk_o));

    assert_pix_rise_on_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk_o) |-> $rose(vco_q));

    assert_byte_rise_on_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk_o) |-> $rose(vco_q));

    assert_sel_quiet_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel_q) |-> !mux_cur);

    assert_byte_min_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(byte_clk_o) && !$past(disable_i)) |-> (hi_run_q >= 8'd4));

    assert_byte_min_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(byte_clk_o) && !$past(disable_i) && $past(lo_run_q) != 8'd0
         && !$past(disable_i, 2)) |-> (lo_run_q >= 8'd4));
endmodule

bind clk_div_tree clk_div_tree_chk u_chk (
    .clk(clk), .rst_n(rst_n), .disable_i(disable_i),
    .pix_clk_o(pix_clk_o), .byte_clk_o(byte_clk_o),
    .vco_q(vco_q), .mux_sel_q(mux_sel_q), .mux_cur(mux_cur)
);

// File: tb/clk_div_tree_tb.sv
module clk_div_tree_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disable_i = 1'b0;
    logic [7:0] post_cfg = 8'd0;
    logic [7:0] mux_cfg = 8'd0;
    logic [7:0] pix_cfg = 8'd0;
    logic       pix_clk, byte_clk;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    clk_div_tree u_dut (
        .clk(clk), .rst_n(rst_n), .disable_i(disable_i),
        .post_cfg_i(post_cfg), .mux_cfg_i(mux_cfg), .pix_cfg_i(pix_cfg),
        .pix_clk_o(pix_clk), .byte_clk_o(byte_clk)
    );

    function automatic logic pick(input bit use_byte);
        return use_byte ? byte_clk : pix_clk;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Measure one full high phase then one full low phase, in clk cycles.
    task automatic measure(input bit use_byte, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (pick(use_byte) == 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (pick(use_byte) == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pick(use_byte) == 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (pick(use_byte) == 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(pix_clk == 1'b0, "R1 pix low in reset", int'(pix_clk), 0);
        check(byte_clk == 1'b0, "R1 byte low in reset", int'(byte_clk), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_pix(input int n, input string tag);
        int hi, lo, m, ehi, elo;
        @(negedge clk); pix_cfg = 8'(n);
        repeat (600) @(negedge clk);
        measure(1'b0, hi, lo);
        m = n + 1;
        if (m == 1) begin ehi = 1; elo = 1; end
        else begin ehi = 2 * ((m + 1) / 2); elo = 2 * m - ehi; end
        check(hi == ehi, tag, hi, ehi);
        check(lo == elo, tag, lo, elo);
    endtask

    task automatic t_byte(input logic [7:0] mcfg, input logic [7:0] pcfg,
                          input int exp_half, input string tag);
        int hi, lo;
        @(negedge clk); mux_cfg = mcfg; post_cfg = pcfg;
        repeat (600) @(negedge clk);
        measure(1'b1, hi, lo);
        check(hi == exp_half, tag, hi, exp_half);
        check(lo == exp_half, tag, lo, exp_half);
    endtask

    // R7: a change in mid-period completes the old period first.
    task automatic t_reprogram();
        int hi = 0, lo = 0, hi2, lo2, guard = 0;
        @(negedge clk); pix_cfg = 8'd7;
        repeat (600) @(negedge clk);
        while (pix_clk == 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (pix_clk == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pix_clk == 1'b1 && guard < 4000) begin
            hi++;
            if (hi == 3) pix_cfg = 8'd1;
            @(negedge clk); guard++;
        end
        while (pix_clk == 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
        hi2 = 0; lo2 = 0;
        while (pix_clk == 1'b1 && guard < 4000) begin hi2++; @(negedge clk); guard++; end
        while (pix_clk == 1'b0 && guard < 4000) begin lo2++; @(negedge clk); guard++; end
        check(hi == 8, "R7 old high completes", hi, 8);
        check(lo == 8, "R7 old low completes", lo, 8);
        check(hi2 == 2, "R7 new high", hi2, 2);
        check(lo2 == 2, "R7 new low", lo2, 2);
    endtask

    // R8: disable holds low and restarts both dividers from zero.
    task automatic t_disable();
        int bad = 0, hi = 0;
        @(negedge clk); pix_cfg = 8'd3; mux_cfg = 8'h02; post_cfg = 8'h01;
        repeat (300) @(negedge clk);
        disable_i = 1'b1;
        @(negedge clk);
        check(!pix_clk && !byte_clk, "R8 low after disable", int'({pix_clk, byte_clk}), 0);
        repeat (50) begin
            @(negedge clk);
            if (pix_clk || byte_clk) bad++;
        end
        check(bad == 0, "R8 held low while disabled", bad, 0);
        disable_i = 1'b0;
        @(negedge clk);
        check(pix_clk && byte_clk, "R8 both rise on first edge", int'({pix_clk, byte_clk}), 3);
        while (pix_clk == 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
        check(hi == 4, "R8 first pix high after restart", hi, 4);
    endtask

    // R9: toggling the select never yields a byte phase shorter than 4.
    task automatic t_switch();
        int run = 0, min_run = 1000, seen = 0;
        logic prev;
        @(negedge clk); post_cfg = 8'h00; mux_cfg = 8'h00;
        repeat (50) @(negedge clk);
        prev = byte_clk;
        for (int i = 0; i < 1200; i++) begin
            if ((i % 37) == 0) mux_cfg = mux_cfg ^ 8'h02;
            @(negedge clk);
            if (byte_clk == prev) run++;
            else begin
                if (seen > 0 && run + 1 < min_run) min_run = run + 1;
                seen++;
                run = 0;
                prev = byte_clk;
            end
        end
        check(min_run >= 4, "R9 minimum byte phase", min_run, 4);
    endtask

    initial begin
        t_reset();
        t_pix(1, "R2 ratio 2");
        t_pix(2, "R2 ratio 3 odd");
        t_pix(4, "R2 ratio 5 odd");
        t_pix(255, "R2 ratio 256");
        t_pix(0, "R3 pass-through");
        t_byte(8'h00, 8'h00, 4, "R4 direct select");
        t_byte(8'h02, 8'h00, 8, "R5 indirect P=0");
        t_byte(8'h02, 8'h02, 24, "R5 indirect P=2");
        t_byte(8'h02, 8'h0F, 128, "R5 indirect P=15");
        t_byte(8'h02, 8'hF1, 16, "R6 upper post bits ignored");
        t_byte(8'hFD, 8'h05, 4, "R6 other select bits ignored");
        t_reprogram();
        t_disable();
        t_switch();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule